// File: doc/BRIEF.md
# Randomized Capacitor Role Selector for a Four-Capacitor Pipeline Stage

This block drives the switches of one pipeline stage that resolves 2.8 bits. The stage has four equal capacitors. All four sample the input. During the amplify phase, one capacitor closes the op-amp loop as the feedback element. The other three each connect to the plus reference, the minus reference or common mode, and so form a three-element ternary DAC. Each conversion, the block takes the six comparator outputs of the sub-ADC and three random bits. It decides the role of every capacitor and registers that decision at the sample-to-amplify boundary.

Swapping roles at random turns capacitor mismatch from a fixed, signal-dependent error into noise that averages out. The swaps form a shallow network of conditional lane exchanges. Each exchange is steered by its own random bit, so the select path is only two multiplexer levels deep. The block also reports the signed level that the stage contributes to the output code. That level depends only on the comparators, never on the chosen permutation.

Top module: `capShuffleSel`

## Requirements
- R1: While `rst` is high at a rising clock edge, every two-bit field of `capSel` becomes 2'b00 (common mode) and `levelOut` becomes 0 after that edge.
- R2: `capSel` and `levelOut` change only after a rising edge at which `phaseEdge` is high and `rst` is low. At all other edges they hold their values, whatever `cmpTherm` and `pnBits` do.
- R3: After a load, `levelOut` (4-bit two's complement) equals the number of ones in `cmpTherm` minus 3, so it ranges from -3 to +3. Bubbles in the thermometer code are tolerated by counting.
- R4: The three DAC codes a, b, c fill in that order: code k (k = 1, 2, 3 for a, b, c) is +1 when level >= k, -1 when level <= -k, and 0 otherwise.
- R5: Before shuffling, lanes 0..3 hold feedback, a, b, c. First layer: `pnBits[0]`=1 exchanges lanes 0 and 1, and `pnBits[1]`=1 exchanges lanes 2 and 3. Second layer: `pnBits[2]`=1 exchanges lane 0 with lane 2 and lane 1 with lane 3. Lane i then drives capacitor i, whose select sits in `capSel[2i+1:2i]`. A bit value of 1 stands for +1 and 0 for -1.
- R6: After every load, exactly one `capSel` field is 2'b11 (feedback/output). At no time is more than one field 2'b11.
- R7: For `pnBits` = 3'b011 (+1, +1, -1) and a thermometer giving a = +1, b = 0, c = 0 (level +1), `capSel` becomes 8'h0D: capacitor 0 on plus reference, capacitor 1 feedback, capacitors 2 and 3 on common mode.
- R8: The sum of the DAC codes at the ports (field 2'b01 = +1, 2'b10 = -1, 2'b00 = 0) always equals `levelOut`, for every `pnBits` value.
- R9: Field encodings: 2'b00 common mode, 2'b01 plus reference, 2'b10 minus reference, 2'b11 op-amp output (feedback).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stage clock |
| rst | input | 1 | Synchronous reset, active high |
| phaseEdge | input | 1 | Strobe marking the sample-to-amplify boundary; selects load at this edge |
| cmpTherm | input | 6 | Sub-ADC comparator decisions (thermometer code) |
| pnBits | input | 3 | Random shuffle bits, 1 = +1, 0 = -1 |
| capSel | output | 8 | Two-bit role select per capacitor, capacitor i in bits 2i+1:2i |
| levelOut | output | 4 | Signed stage level, -3..+3 |

## Verification
A wrong lane exchange or a stuck random-bit path shows at the first load that uses the affected bit. It appears as a misplaced 2'b11 field or a DAC code on the wrong capacitor. The code sum still matches the level, so only an exact per-field comparison catches it. A fault in the level decode breaks the code-sum relation with `levelOut` in the cycle after the load. A faulty load enable shows as `capSel` moving while `phaseEdge` is low, or as a stale value after the strobe. Every load is compared against an independent model on the next clock.

// File: rtl/capsel_pkg.sv
package capsel_pkg;
  localparam int NUM_CAPS = 4;
  localparam int NUM_DAC  = NUM_CAPS - 1;
  localparam int PN_W     = 3;
  localparam int SEL_W    = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CM  = 2'b00,
    SEL_RP  = 2'b01,
    SEL_RN  = 2'b10,
    SEL_OUT = 2'b11
  } selT;

  typedef struct packed {
    logic clr;
    logic load;
  } strobeT;
endpackage

// File: rtl/capSelCtrl.sv
module capSelCtrl
  import capsel_pkg::*;
(
  input  logic   rst,
  input  logic   phaseEdge,
  output strobeT strobes
);
  // Reset wins over a load at the same edge (R1, R2)
  always_comb begin
    strobes.clr  = rst;
    strobes.load = phaseEdge & ~rst;
  end
endmodule

// File: rtl/capSelDecode.sv
module capSelDecode
  import capsel_pkg::*;
#(
  parameter int NUM_CMP = 6,
  parameter int LVL_W   = 4
) (
  input  logic [NUM_CMP-1:0]         therm,
  output logic [SEL_W*NUM_DAC-1:0]   dacCodes,
  output logic signed [LVL_W-1:0]    level
);
  localparam int CNT_W = $clog2(NUM_CMP + 1);
  localparam int HALF  = NUM_CMP / 2;

  logic [CNT_W-1:0] onesCnt;

  // Counting ones tolerates thermometer bubbles (R3)
  always_comb begin
    onesCnt = '0;
    for (int i = 0; i < NUM_CMP; i++) onesCnt = onesCnt + CNT_W'(therm[i]);
    level = LVL_W'(onesCnt) - LVL_W'(HALF);
  end

  // Codes fill a, then b, then c (R4)
  always_comb begin
    for (int k = 0; k < NUM_DAC; k++) begin
      if (level > k)
        dacCodes[SEL_W*k +: SEL_W] = SEL_RP;
      else if (level < -k)
        dacCodes[SEL_W*k +: SEL_W] = SEL_RN;
      else
        dacCodes[SEL_W*k +: SEL_W] = SEL_CM;
    end
  end
endmodule

// File: rtl/capSelSwapNet.sv
module capSelSwapNet
  import capsel_pkg::*;
(
  input  logic [SEL_W*NUM_CAPS-1:0] laneIn,
  input  logic [PN_W-1:0]           pn,
  output logic [SEL_W*NUM_CAPS-1:0] laneOut
);
  localparam int PAIRS = NUM_CAPS / 2;

  logic [SEL_W*NUM_CAPS-1:0] midLane;

  // First layer: neighbour pairs, each steered by its own bit (R5)
  for (genvar p = 0; p < PAIRS; p++) begin : gPair
    localparam int LO = 2 * p;
    localparam int HI = 2 * p + 1;
    assign midLane[SEL_W*LO +: SEL_W] = pn[p] ? laneIn[SEL_W*HI +: SEL_W]
                                              : laneIn[SEL_W*LO +: SEL_W];
    assign midLane[SEL_W*HI +: SEL_W] = pn[p] ? laneIn[SEL_W*LO +: SEL_W]
                                              : laneIn[SEL_W*HI +: SEL_W];
  end

  // Second layer: halves exchanged by the last bit (R5)
  for (genvar k = 0; k < PAIRS; k++) begin : gHalf
    assign laneOut[SEL_W*k +: SEL_W] = pn[PN_W-1] ? midLane[SEL_W*(k+PAIRS) +: SEL_W]
                                                  : midLane[SEL_W*k +: SEL_W];
    assign laneOut[SEL_W*(k+PAIRS) +: SEL_W] = pn[PN_W-1] ? midLane[SEL_W*k +: SEL_W]
                                                          : midLane[SEL_W*(k+PAIRS) +: SEL_W];
  end
endmodule

// File: rtl/capSelDatapath.sv
module capSelDatapath
  import capsel_pkg::*;
#(
  parameter int NUM_CMP = 6,
  parameter int LVL_W   = 4
) (
  input  logic                        clk,
  input  strobeT                      strobes,
  input  logic [NUM_CMP-1:0]          cmpTherm,
  input  logic [PN_W-1:0]             pnBits,
  output logic [SEL_W*NUM_CAPS-1:0]   capSel,
  output logic signed [LVL_W-1:0]     levelOut
);
  logic [SEL_W*NUM_DAC-1:0]  dacCodes;
  logic signed [LVL_W-1:0]   level;
  logic [SEL_W*NUM_CAPS-1:0] laneIn;
  logic [SEL_W*NUM_CAPS-1:0] laneOut;

  capSelDecode #(.NUM_CMP(NUM_CMP), .LVL_W(LVL_W)) uDecode (
    .therm    (cmpTherm),
    .dacCodes (dacCodes),
    .level    (level)
  );

  // Lane 0 carries the feedback role, lanes 1..3 carry a, b, c
  assign laneIn = {dacCodes, SEL_OUT};

  capSelSwapNet uSwap (
    .laneIn  (laneIn),
    .pn      (pnBits),
    .laneOut (laneOut)
  );

  always_ff @(posedge clk) begin
    if (strobes.clr) begin
      capSel   <= '0;
      levelOut <= '0;
    end else if (strobes.load) begin
      capSel   <= laneOut;
      levelOut <= level;
    end
  end
endmodule

// File: rtl/capShuffleSel.sv
module capShuffleSel
  import capsel_pkg::*;
#(
  parameter int NUM_CMP = 6,
  parameter int LVL_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       phaseEdge,
  input  logic [NUM_CMP-1:0]         cmpTherm,
  input  logic [PN_W-1:0]            pnBits,
  output logic [SEL_W*NUM_CAPS-1:0]  capSel,
  output logic signed [LVL_W-1:0]    levelOut
);
  strobeT strobes;

  capSelCtrl uCtrl (
    .rst       (rst),
    .phaseEdge (phaseEdge),
    .strobes   (strobes)
  );

  capSelDatapath #(.NUM_CMP(NUM_CMP), .LVL_W(LVL_W)) uPath (
    .clk      (clk),
    .strobes  (strobes),
    .cmpTherm (cmpTherm),
    .pnBits   (pnBits),
    .capSel   (capSel),
    .levelOut (levelOut)
  );
endmodule

// File: rtl/capSelChecker.sv
module capSelChecker
  import capsel_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      phaseEdge,
  input logic [SEL_W*NUM_CAPS-1:0] capSel,
  input logic signed [LVL_W-1:0]   levelOut
);
  logic [NUM_CAPS-1:0]     fbFlags;
  logic signed [LVL_W-1:0] codeSum;
  logic                    rstQ = 1'b0;

  always_comb begin
    codeSum = '0;
    for (int i = 0; i < NUM_CAPS; i++) begin
      fbFlags[i] = (capSel[SEL_W*i +: SEL_W] == SEL_OUT);
      if (capSel[SEL_W*i +: SEL_W] == SEL_RP) codeSum = codeSum + LVL_W'(1);
      if (capSel[SEL_W*i +: SEL_W] == SEL_RN) codeSum = codeSum - LVL_W'(1);
    end
  end

  always @(posedge clk) begin
    if (rstQ) begin
      AST_RESET_CM: assert (capSel == '0 && levelOut == '0); // R1
    end
    rstQ <= rst;
  end

  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    !phaseEdge |=> $stable(capSel) && $stable(levelOut)); // R2

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    (levelOut >= -3) && (levelOut <= 3)); // R3

  AST_ONE_FB_LOAD: assert property (@(posedge clk) disable iff (rst)
    phaseEdge |=> ($countones(fbFlags) == 1)); // R6

  AST_FB_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fbFlags)); // R6

  AST_SUM_LEVEL: assert property (@(posedge clk) disable iff (rst)
    codeSum == levelOut); // R8
endmodule

bind capShuffleSel capSelChecker #(.LVL_W(LVL_W)) uChk (
  .clk       (clk),
  .rst       (rst),
  .phaseEdge (phaseEdge),
  .capSel    (capSel),
  .levelOut  (levelOut)
);

// File: tb/sim_capShuffleSel.sv
module sim_capShuffleSel;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst = 1'b1;
  logic              phaseEdge = 1'b0;
  logic [5:0]        cmpTherm = '0;
  logic [2:0]        pnBits = '0;
  logic [7:0]        capSel;
  logic signed [3:0] levelOut;

  capShuffleSel u0 (
    .clk(clk), .rst(rst), .phaseEdge(phaseEdge),
    .cmpTherm(cmpTherm), .pnBits(pnBits),
    .capSel(capSel), .levelOut(levelOut)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  string curTag = "R1";
  logic [7:0] expSel = '0;
  int expLvl = 0;

  // Behavioural model: role per lane as integer (0 cm, 1 plus, -1 minus, 2 feedback)
  function automatic void model(input logic [5:0] th, input logic [2:0] pn,
                                output logic [7:0] sel, output int lvl);
    int role[4];
    int t;
    int ones = 0;
    for (int i = 0; i < 6; i++) ones += th[i];
    lvl = ones - 3;
    role[0] = 2;
    for (int k = 1; k <= 3; k++) role[k] = (lvl >= k) ? 1 : ((lvl <= -k) ? -1 : 0);
    if (pn[0]) begin t = role[0]; role[0] = role[1]; role[1] = t; end
    if (pn[1]) begin t = role[2]; role[2] = role[3]; role[3] = t; end
    if (pn[2]) begin
      t = role[0]; role[0] = role[2]; role[2] = t;
      t = role[1]; role[1] = role[3]; role[3] = t;
    end
    for (int i = 0; i < 4; i++)
      sel[2*i +: 2] = (role[i] == 2) ? 2'b11 : (role[i] == 1) ? 2'b01 :
                      (role[i] == -1) ? 2'b10 : 2'b00;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      expSel = '0;
      expLvl = 0;
    end else if (phaseEdge) begin
      model(cmpTherm, pnBits, expSel, expLvl);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      chk({curTag, " capSel"}, int'(capSel), int'(expSel));
      chk({curTag, " levelOut"}, int'(levelOut), expLvl);
    end
  end

  function automatic logic [5:0] thermOf(input int lvl);
    return 6'((1 << (lvl + 3)) - 1);
  endfunction

  task automatic loadOne(input logic [5:0] th, input logic [2:0] pn);
    @(negedge clk);
    cmpTherm = th; pnBits = pn; phaseEdge = 1'b1;
    @(negedge clk);
    phaseEdge = 1'b0;
  endtask

  function automatic int fbCount(input logic [7:0] s);
    int n = 0;
    for (int i = 0; i < 4; i++) if (s[2*i +: 2] == 2'b11) n++;
    return n;
  endfunction

  function automatic int codeSum(input logic [7:0] s);
    int n = 0;
    for (int i = 0; i < 4; i++) begin
      if (s[2*i +: 2] == 2'b01) n++;
      if (s[2*i +: 2] == 2'b10) n--;
    end
    return n;
  endfunction

  initial begin
    logic [7:0] held;
    logic [7:0] lfsr = 8'hA5;
    repeat (3) @(negedge clk);
    curTag = "R1";
    chk("R1 reset capSel", int'(capSel), 0);
    chk("R1 reset levelOut", int'(levelOut), 0);
    @(negedge clk); rst = 1'b0;

    curTag = "R7";
    loadOne(thermOf(1), 3'b011);
    chk("R7 example capSel", int'(capSel), 8'h0D);
    chk("R7 example levelOut", int'(levelOut), 1);

    curTag = "R2";
    held = capSel;
    @(negedge clk); cmpTherm = 6'h3F; pnBits = 3'b101;
    repeat (3) @(negedge clk);
    chk("R2 hold without edge", int'(capSel), int'(held));
    chk("R2 level hold", int'(levelOut), 1);

    curTag = "R5";
    for (int lv = -3; lv <= 3; lv++) begin
      for (int p = 0; p < 8; p++) begin
        loadOne(thermOf(lv), 3'(p));
        chk("R3 level", int'(levelOut), lv);
        chk("R6 one feedback", fbCount(capSel), 1);
        chk("R8 code sum", codeSum(capSel), int'(levelOut));
      end
    end

    curTag = "R4";
    loadOne(thermOf(-2), 3'b000);
    chk("R4 fill order neg2", int'(capSel), 8'b00_10_10_11);
    loadOne(thermOf(3), 3'b100);
    chk("R5 half swap", int'(capSel), 8'b01_11_01_01);

    curTag = "R3";
    loadOne(6'b101010, 3'b010);
    chk("R3 bubble level", int'(levelOut), 0);

    curTag = "R9";
    for (int n = 0; n < 40; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      loadOne(lfsr[5:0], lfsr[7:5]);
      chk("R6 random feedback", fbCount(capSel), 1);
    end

    curTag = "R1";
    @(negedge clk); rst = 1'b1; phaseEdge = 1'b1;
    @(negedge clk);
    chk("R1 reset beats load", int'(capSel), 0);
    rst = 1'b0; phaseEdge = 1'b0;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule